// File: doc/BRIEF.md
# Inter-Processor Doorbell Unit

This block lets software on one processor interrupt one or more other processors. Each processor has its own register port into the unit. A processor rings a doorbell with a single write to the ring register. That write names one of the doorbells and gives a bitmap of the processors that should receive it. Every named processor latches the doorbell in its own cause register. The sender may name itself. The latched bit stays set until that processor clears it.

Each processor also has a mask register that decides which of its latched doorbells may interrupt it. When any latched doorbell is also enabled, the unit raises that processor's interrupt line toward the interrupt controller core. An identity read then returns the shared doorbell identity 0 while something is pending, and the spurious identity 1023 otherwise. Cause bits are cleared by writing to the cause register. A write of zero empties it completely.

Top module: `dbell_unit`

## Requirements
- R1: After reset every cause and mask bit is zero, every `irq_out` bit is low, and an identity read (offset 0x10) returns 0x3FF.
- R2: A write to offset 0x04 with a doorbell number n in bits [7:0] and a target bitmap in bits [8+NCPU-1:8] sets cause bit n of every processor c whose bitmap bit 8+c is set, including the writer. Processors not named keep their cause value.
- R3: A ring write whose doorbell number is NBELL or higher changes no cause register.
- R4: Cause bits are sticky. Later rings add bits to those already latched. Rings issued on several ports in the same cycle to one processor all land.
- R5: A write to a processor's cause register (offset 0x08) keeps only the cause bits whose matching write-data bit in [NBELL-1:0] is one. A write of zero clears every bit.
- R6: When a cause write and a ring reach the same processor in the same cycle, the rung bit ends up set.
- R7: A write to offset 0x0C loads the writer's mask from bits [NBELL-1:0]. Mask reads return those bits with all upper bits zero. No other access changes the mask.
- R8: `irq_out[c]` is high exactly when processor c has a cause bit whose mask bit is also set. It follows a register write in the first cycle after the clock edge that takes the write.
- R9: An identity read returns 0 when the reading processor has a pending enabled doorbell, and 0x3FF when it has none.
- R10: Read data appears on `bus_rdata` with `bus_rvalid` high in the cycle after the read strobe. Cause reads give bits [NBELL-1:0] with the upper bits zero. Any other offset reads zero.
- R11: Cause, mask and identity accesses on port c touch only processor c's state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | NCPU | Write strobe, one per processor port |
| bus_rd | input | NCPU | Read strobe, one per processor port |
| bus_addr | input | NCPU*AW | Byte offset per port, port c in slice c |
| bus_wdata | input | NCPU*DW | Write data per port |
| bus_rdata | output | NCPU*DW | Read data per port |
| bus_rvalid | output | NCPU | Read data valid per port |
| irq_out | output | NCPU | Doorbell interrupt request per processor |

## Verification
Each write lands at the next rising edge, so the cause and mask contents and `irq_out` are checked at the falling edge that follows that edge. A read strobe gives data one cycle later. The read driver computes the expected word from a bench model when it issues the read and queues it. The monitor pops the entry at the falling edge where `bus_rvalid` shows. Collisions are built by driving several ports in a single cycle: two rings on different ports, and a clear on one port against a ring on another. Reads are always issued one cycle after the writes they observe, so an expected value never depends on how a same-cycle access is ordered.

// File: rtl/dbell_pkg.sv
package dbell_pkg;

    // register offsets within each processor's port
    localparam logic [7:0] OFF_RING  = 8'h04;
    localparam logic [7:0] OFF_CAUSE = 8'h08;
    localparam logic [7:0] OFF_MASK  = 8'h0C;
    localparam logic [7:0] OFF_IDENT = 8'h10;

    // ring write layout
    localparam int unsigned BELL_NUM_W = 8;
    localparam int unsigned MAP_LSB    = 8;

    // identity values
    localparam int unsigned IDENT_W    = 10;
    localparam logic [IDENT_W-1:0] IDENT_BELL  = 10'd0;
    localparam logic [IDENT_W-1:0] IDENT_SPUR  = 10'h3FF;

    typedef enum logic [1:0] {
        RSEL_ZERO  = 2'd0,
        RSEL_CAUSE = 2'd1,
        RSEL_MASK  = 2'd2,
        RSEL_IDENT = 2'd3
    } rsel_e;

endpackage

// File: rtl/dbell_port_decode.sv
module dbell_port_decode
    import dbell_pkg::*;
#(
    parameter int unsigned NCPU  = 4,
    parameter int unsigned NBELL = 8,
    parameter int unsigned AW    = 8,
    parameter int unsigned DW    = 32
) (
    input  logic             wr_en,
    input  logic             rd_en,
    input  logic [AW-1:0]    addr,
    input  logic [DW-1:0]    wdata,
    output logic             ring_req,
    output logic [NBELL-1:0] ring_bell,
    output logic [NCPU-1:0]  ring_map,
    output logic             cause_we,
    output logic             mask_we,
    output logic [NBELL-1:0] wr_bits,
    output logic             rd_req,
    output rsel_e            rd_sel
);

    logic hit_ring;
    logic hit_cause;
    logic hit_mask;
    logic hit_ident;
    logic unused_bits;

    assign hit_ring  = (addr == AW'(OFF_RING));
    assign hit_cause = (addr == AW'(OFF_CAUSE));
    assign hit_mask  = (addr == AW'(OFF_MASK));
    assign hit_ident = (addr == AW'(OFF_IDENT));

    // one-hot doorbell select; out-of-range numbers select nothing
    for (genvar b = 0; b < NBELL; b++) begin : g_bell
        assign ring_bell[b] = wr_en && hit_ring
                              && (wdata[BELL_NUM_W-1:0] == BELL_NUM_W'(b));
    end

    assign ring_req    = |ring_bell;
    assign ring_map    = wdata[MAP_LSB +: NCPU];
    assign cause_we    = wr_en && hit_cause;
    assign mask_we     = wr_en && hit_mask;
    assign wr_bits     = wdata[NBELL-1:0];
    assign rd_req      = rd_en;
    assign unused_bits = ^wdata;

    always_comb begin
        if (hit_cause)      rd_sel = RSEL_CAUSE;
        else if (hit_mask)  rd_sel = RSEL_MASK;
        else if (hit_ident) rd_sel = RSEL_IDENT;
        else                rd_sel = RSEL_ZERO;
    end

    always_comb begin
        AST_ONE_BELL: assert ($onehot0(ring_bell)); // R2
    end

endmodule

// File: rtl/dbell_ring_merge.sv
module dbell_ring_merge #(
    parameter int unsigned NCPU  = 4,
    parameter int unsigned NBELL = 8
) (
    input  logic [NCPU-1:0]       ring_req,
    input  logic [NCPU*NBELL-1:0] ring_bell,
    input  logic [NCPU*NCPU-1:0]  ring_map,
    output logic [NCPU*NBELL-1:0] set_vec
);

    // every source ring is ORed into each named target
    always_comb begin
        set_vec = '0;
        for (int t = 0; t < NCPU; t++) begin
            for (int s = 0; s < NCPU; s++) begin
                if (ring_req[s] && ring_map[s*NCPU + t]) begin
                    set_vec[t*NBELL +: NBELL] = set_vec[t*NBELL +: NBELL]
                                              | ring_bell[s*NBELL +: NBELL];
                end
            end
        end
    end

endmodule

// File: rtl/dbell_cpu_slot.sv
module dbell_cpu_slot
    import dbell_pkg::*;
#(
    parameter int unsigned NBELL = 8,
    parameter int unsigned DW    = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NBELL-1:0] set_bits,
    input  logic             cause_we,
    input  logic             mask_we,
    input  logic [NBELL-1:0] wr_bits,
    input  logic             rd_req,
    input  rsel_e            rd_sel,
    output logic [DW-1:0]    rdata,
    output logic             rvalid,
    output logic             irq
);

    localparam int unsigned PAD_W = DW - NBELL;
    localparam int unsigned ID_PAD = DW - IDENT_W;

    typedef struct packed {
        logic [NBELL-1:0] cause;
        logic [NBELL-1:0] mask;
        logic [DW-1:0]    rdata;
        logic             rvalid;
    } slot_t;

    slot_t st_d, st_q;
    logic  pend;

    assign pend = |(st_q.cause & st_q.mask);

    always_comb begin
        st_d = st_q;
        if (cause_we) begin
            st_d.cause = st_q.cause & wr_bits;
        end
        // a ring landing in the same cycle survives the clear
        st_d.cause = st_d.cause | set_bits;
        if (mask_we) begin
            st_d.mask = wr_bits;
        end
        st_d.rvalid = rd_req;
        st_d.rdata  = '0;
        if (rd_req) begin
            unique case (rd_sel)
                RSEL_CAUSE: st_d.rdata = {{PAD_W{1'b0}}, st_q.cause};
                RSEL_MASK:  st_d.rdata = {{PAD_W{1'b0}}, st_q.mask};
                RSEL_IDENT: st_d.rdata = {{ID_PAD{1'b0}},
                                          pend ? IDENT_BELL : IDENT_SPUR};
                default:    st_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rdata  = st_q.rdata;
    assign rvalid = st_q.rvalid;
    assign irq    = pend;

    AST_RING_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_bits) |=> ((st_q.cause & $past(set_bits)) == $past(set_bits))); // R6

    AST_CLEAR_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        (cause_we && (wr_bits == '0) && (set_bits == '0)) |=> (st_q.cause == '0)); // R5

    AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (!cause_we) |=> ((st_q.cause & $past(st_q.cause)) == $past(st_q.cause))); // R4

    AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!mask_we) |=> $stable(st_q.mask)); // R7

    AST_RD_TIMING: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> rvalid); // R10

    AST_IDENT_PEND: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && (rd_sel == RSEL_IDENT) && irq) |=> (rdata == '0)); // R9

    AST_IRQ_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (cause_we && (wr_bits == '0) && (set_bits == '0)) |=> !irq); // R8

endmodule

// File: rtl/dbell_unit.sv
module dbell_unit
    import dbell_pkg::*;
#(
    parameter int unsigned NCPU  = 4,
    parameter int unsigned NBELL = 8,
    parameter int unsigned AW    = 8,
    parameter int unsigned DW    = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NCPU-1:0]    bus_wr,
    input  logic [NCPU-1:0]    bus_rd,
    input  logic [NCPU*AW-1:0] bus_addr,
    input  logic [NCPU*DW-1:0] bus_wdata,
    output logic [NCPU*DW-1:0] bus_rdata,
    output logic [NCPU-1:0]    bus_rvalid,
    output logic [NCPU-1:0]    irq_out
);

    logic [NCPU-1:0]       ring_req;
    logic [NCPU*NBELL-1:0] ring_bell;
    logic [NCPU*NCPU-1:0]  ring_map;
    logic [NCPU*NBELL-1:0] set_vec;
    logic [NCPU-1:0]       cause_we;
    logic [NCPU-1:0]       mask_we;
    logic [NCPU*NBELL-1:0] wr_bits;
    logic [NCPU-1:0]       rd_req;
    rsel_e                 rd_sel [NCPU];

    for (genvar c = 0; c < NCPU; c++) begin : g_port
        dbell_port_decode #(
            .NCPU (NCPU),
            .NBELL(NBELL),
            .AW   (AW),
            .DW   (DW)
        ) u_dec (
            .wr_en    (bus_wr[c]),
            .rd_en    (bus_rd[c]),
            .addr     (bus_addr[c*AW +: AW]),
            .wdata    (bus_wdata[c*DW +: DW]),
            .ring_req (ring_req[c]),
            .ring_bell(ring_bell[c*NBELL +: NBELL]),
            .ring_map (ring_map[c*NCPU +: NCPU]),
            .cause_we (cause_we[c]),
            .mask_we  (mask_we[c]),
            .wr_bits  (wr_bits[c*NBELL +: NBELL]),
            .rd_req   (rd_req[c]),
            .rd_sel   (rd_sel[c])
        );
    end

    dbell_ring_merge #(
        .NCPU (NCPU),
        .NBELL(NBELL)
    ) u_merge (
        .ring_req (ring_req),
        .ring_bell(ring_bell),
        .ring_map (ring_map),
        .set_vec  (set_vec)
    );

    for (genvar c = 0; c < NCPU; c++) begin : g_slot
        dbell_cpu_slot #(
            .NBELL(NBELL),
            .DW   (DW)
        ) u_slot (
            .clk     (clk),
            .rst_n   (rst_n),
            .set_bits(set_vec[c*NBELL +: NBELL]),
            .cause_we(cause_we[c]),
            .mask_we (mask_we[c]),
            .wr_bits (wr_bits[c*NBELL +: NBELL]),
            .rd_req  (rd_req[c]),
            .rd_sel  (rd_sel[c]),
            .rdata   (bus_rdata[c*DW +: DW]),
            .rvalid  (bus_rvalid[c]),
            .irq     (irq_out[c])
        );
    end

    AST_IRQ_QUIET_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (irq_out == '0)); // R1

endmodule

// File: tb/tb_dbell_unit.sv
module tb_dbell_unit;

    localparam int NCPU  = 4;
    localparam int NBELL = 8;
    localparam int AW    = 8;
    localparam int DW    = 32;
    localparam time CLK_PERIOD = 10ns;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic [NCPU-1:0]    bus_wr = '0;
    logic [NCPU-1:0]    bus_rd = '0;
    logic [NCPU*AW-1:0] bus_addr = '0;
    logic [NCPU*DW-1:0] bus_wdata = '0;
    logic [NCPU*DW-1:0] bus_rdata;
    logic [NCPU-1:0]    bus_rvalid;
    logic [NCPU-1:0]    irq_out;

    dbell_unit #(.NCPU(NCPU), .NBELL(NBELL), .AW(AW), .DW(DW)) dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_rvalid(bus_rvalid), .irq_out(irq_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    typedef struct {
        int          cpu;
        logic [31:0] data;
        string       tag;
    } exp_t;

    exp_t       sb_q[$];
    int         n_checks = 0;
    int         n_errors = 0;
    bit         finished = 1'b0;
    logic [7:0] cause_m [NCPU];
    logic [7:0] mask_m  [NCPU];

    task automatic report();
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    endtask

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] model_read(int cpu, logic [7:0] a);
        case (a)
            8'h08:   return {24'd0, cause_m[cpu]};
            8'h0C:   return {24'd0, mask_m[cpu]};
            8'h10:   return ((cause_m[cpu] & mask_m[cpu]) != 0) ? 32'd0 : 32'h3FF;
            default: return 32'd0;
        endcase
    endfunction

    function automatic logic [NCPU-1:0] model_irq();
        logic [NCPU-1:0] v;
        for (int c = 0; c < NCPU; c++) v[c] = (cause_m[c] & mask_m[c]) != 0;
        return v;
    endfunction

    // driver helpers: called at a falling edge, return at the next one
    task automatic put(int p, bit we, bit re, logic [7:0] a, logic [31:0] d);
        bus_wr[p]              = we;
        bus_rd[p]              = re;
        bus_addr[p*AW +: AW]   = a;
        bus_wdata[p*DW +: DW]  = d;
    endtask

    task automatic step();
        @(negedge clk);
        bus_wr = '0;
        bus_rd = '0;
    endtask

    task automatic model_ring(int bell, logic [NCPU-1:0] map);
        if (bell < NBELL)
            for (int t = 0; t < NCPU; t++)
                if (map[t]) cause_m[t] = cause_m[t] | 8'(1 << bell);
    endtask

    task automatic ring(int src, int bell, logic [NCPU-1:0] map);
        put(src, 1'b1, 1'b0, 8'h04, {20'd0, map, 8'(bell)});
        step();
        model_ring(bell, map);
    endtask

    task automatic cause_wr(int cpu, logic [31:0] v);
        put(cpu, 1'b1, 1'b0, 8'h08, v);
        step();
        cause_m[cpu] = cause_m[cpu] & v[7:0];
    endtask

    task automatic mask_wr(int cpu, logic [31:0] v);
        put(cpu, 1'b1, 1'b0, 8'h0C, v);
        step();
        mask_m[cpu] = v[7:0];
    endtask

    task automatic rd(int cpu, logic [7:0] a, string tag);
        exp_t e;
        e.cpu  = cpu;
        e.data = model_read(cpu, a);
        e.tag  = tag;
        sb_q.push_back(e);
        put(cpu, 1'b0, 1'b1, a, 32'd0);
        step();
    endtask

    task automatic check_irq(string tag);
        check(tag, 32'(irq_out), 32'(model_irq()));
    endtask

    // monitor: compare read results in the cycle after the strobe (R10)
    initial begin
        forever begin
            @(negedge clk);
            #1;
            for (int c = 0; c < NCPU; c++) begin
                if (rst_n && bus_rvalid[c]) begin
                    if (sb_q.size() == 0) begin
                        n_checks++;
                        n_errors++;
                        $display("FAIL R10: unexpected rvalid on port %0d actual=1 expected=0", c);
                    end else begin
                        exp_t e;
                        e = sb_q.pop_front();
                        check($sformatf("%s port%0d", e.tag, c),
                              bus_rdata[c*DW +: DW], e.data);
                        if (e.cpu != c) begin
                            n_checks++;
                            n_errors++;
                            $display("FAIL R10: data on port %0d actual=%0d expected=%0d", c, c, e.cpu);
                        end
                    end
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual=timeout expected=done");
        report();
    end

    initial begin
        for (int c = 0; c < NCPU; c++) begin
            cause_m[c] = '0;
            mask_m[c]  = '0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        check_irq("R1 irq after reset");
        rd(0, 8'h08, "R1 cause reset");
        rd(0, 8'h0C, "R1 mask reset");
        rd(0, 8'h10, "R1 ident spurious");

        // R2 / R11: ring doorbell 2 on processors 1 and 2
        ring(0, 2, 4'b0110);
        for (int c = 0; c < NCPU; c++) rd(c, 8'h08, "R2 R11 cause after ring");

        // R2 / R4: self ring accumulates with earlier bit
        ring(1, 5, 4'b0010);
        rd(1, 8'h08, "R4 sticky accumulate");

        // R3: out-of-range doorbell numbers
        ring(2, 9, 4'b1111);
        ring(2, 8, 4'b1111);
        rd(3, 8'h08, "R3 out-of-range ignored");
        rd(1, 8'h08, "R3 out-of-range ignored");

        // R8: no interrupt while masked, then enable
        check_irq("R8 masked no irq");
        mask_wr(1, 32'hFFFF_FF20);
        check_irq("R8 irq after unmask");
        rd(1, 8'h0C, "R7 mask upper bits zero");
        rd(2, 8'h0C, "R11 mask isolation");

        // R9: identity reads
        rd(1, 8'h10, "R9 ident pending");
        rd(2, 8'h10, "R9 ident masked");

        // R5: selective clear keeps bit 2, drops bit 5
        cause_wr(1, 32'h0000_0004);
        check_irq("R8 irq drops after clear");
        rd(1, 8'h08, "R5 selective clear");
        cause_wr(2, 32'h0);
        rd(2, 8'h08, "R5 clear all");
        rd(1, 8'h08, "R11 clear isolation");

        // R4: two ports ring the same target in one cycle
        put(0, 1'b1, 1'b0, 8'h04, {20'd0, 4'b1000, 8'd1});
        put(2, 1'b1, 1'b0, 8'h04, {20'd0, 4'b1000, 8'd6});
        step();
        model_ring(1, 4'b1000);
        model_ring(6, 4'b1000);
        rd(3, 8'h08, "R4 simultaneous rings");

        // R6: clear on port 3 against ring of doorbell 0 from port 0
        put(3, 1'b1, 1'b0, 8'h08, 32'h0);
        put(0, 1'b1, 1'b0, 8'h04, {20'd0, 4'b1000, 8'd0});
        step();
        cause_m[3] = 8'h01;
        rd(3, 8'h08, "R6 ring wins over clear");
        mask_wr(3, 32'h0000_0001);
        check_irq("R8 irq on processor 3");
        rd(3, 8'h10, "R9 ident pending cpu3");

        // R10: unmapped offsets and the ring offset read zero
        rd(0, 8'h20, "R10 unmapped read");
        rd(0, 8'h04, "R10 ring offset read");

        @(negedge clk);
        @(negedge clk);
        check("R10 all reads returned", 32'(sb_q.size()), 32'd0);
        report();
    end

endmodule